// File: doc/BRIEF.md
# Configuration Image Loader

This block copies a configuration image from a byte-wide read-only memory into the configuration port of a programmable-logic device. The port is 16 bits wide. On a start request, the loader scans the image for a two-byte sync marker. It then checks that the stretch from the marker to the last byte holds a whole number of 16-bit words. Next it drives the target through a fixed sequence of control strobes. The strobes are a local-bus reset, a reload pulse and a program pulse.

Once the target reports that it is ready to receive, the loader streams the image as 16-bit words. Each word is paced in one of two ways, chosen from a version nibble in the target's status word: a ready handshake, or a fixed wait. After every write the loader confirms the target is still in its receive state. After the last word it waits for the target's completion input. Any failure inside an attempt restarts the whole attempt, up to a fixed number of attempts. The final outcome is a done flag or a two-bit error code, and both are held until the next start.

All pulse widths, poll intervals and poll limits are parameters counted in clock cycles.

Top module: `cfg_image_loader`

## Requirements
- R1: The image begins at the first address where byte 0xFF is immediately followed by byte 0x20. If no such pair exists, or the image is shorter than two bytes, the load ends with error code 1 (invalid image), no strobe pulses and no writes.
- R2: If the byte count from the marker to the end of the image is odd, the load ends with error code 1, no strobe pulses and no writes.
- R3: Words are written in image order, starting at the marker. The first byte of each pair goes on bits 15:8 and the second on bits 7:0. An attempt writes exactly (length - marker address)/2 words.
- R4: Every attempt starts with the strobes in this order: local-bus reset high then low, reload low-high-low, then program high then low. Each high phase lasts PULSE_W cycles.
- R5: After the strobes, status bit 1 (ready-to-receive) is polled up to INIT_TRIES times, POLL_GAP cycles apart. If it never sets, the attempt fails with error code 2 (timeout).
- R6: When status bits 15:12 equal 0x5, each write occurs only after status bit 2 (transmit ready) has been seen set. If bit 2 stays clear for TX_TRIES polls, the attempt fails with error code 2.
- R7: For any other version nibble, each write is preceded by a fixed wait of at least (FIXED_POLLS-1)*POLL_GAP cycles, and status bit 2 is ignored.
- R8: The status is checked in the cycle after each write. If bit 1 is clear, the attempt fails with error code 3 (I/O).
- R9: After the last word, the completion input is polled up to DONE_TRIES times; if it never sets, the attempt fails with error code 2. On success, one more local-bus reset pulse and one more reload pulse are issued, then done rises with error code 0.
- R10: A failed attempt restarts from the strobe sequence. At most MAX_ATTEMPTS attempts are made, and the error code of the last failed attempt is reported.
- R11: If the memory-present input is low when the image checks pass, the load ends with error code 3 before any strobe pulse or write.
- R12: busy is high from the cycle after an accepted start until the result is posted. done and the error code keep their value until the next start, and a start request during busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a load |
| img_len_i | input | LEN_W | Image length in bytes |
| rom_addr_o | output | LEN_W | Byte address into the image memory |
| rom_data_i | input | 8 | Image byte at rom_addr_o (combinational read) |
| mem_present_i | input | 1 | Configuration memory present |
| stat_i | input | 16 | Target status word: bit 1 ready-to-receive, bit 2 transmit ready, bits 15:12 version |
| cfg_done_i | input | 1 | Target completion flag |
| cfg_wdata_o | output | 16 | Configuration word |
| cfg_we_o | output | 1 | Single-cycle write strobe for cfg_wdata_o |
| lbus_rst_o | output | 1 | Local-bus reset strobe |
| reload_o | output | 1 | Configuration reload strobe |
| prog_o | output | 1 | Program strobe |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| err_o | output | 2 | 0 none, 1 invalid image, 2 timeout, 3 I/O |

## Verification
The bench builds the loader with PULSE_W=2, POLL_GAP=3 and FIXED_POLLS=4. It keeps the full poll limits of 50, 100 and 200 and three attempts. With these values, even a load that times out on every attempt finishes within a few thousand cycles, so each retry path runs to the end. The short, distinct pulse width lets the target model check the width of every strobe. The fixed-wait window of at least nine cycles is clearly longer than the gap the handshake path produces, so the two pacing modes can be told apart.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_IMAGE   = 2'd1,
        ERR_TIMEOUT = 2'd2,
        ERR_IO      = 2'd3
    } ldr_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SCAN, S_PULSE, S_INIT, S_FETCH_H, S_FETCH_L,
        S_PACE, S_WRITE, S_VERIFY, S_DONEW
    } ldr_state_e;

    typedef enum logic [1:0] {
        P_INIT, P_TX, P_WAIT, P_DONE
    } poll_sel_e;

    typedef struct packed {
        logic lbr;
        logic rld;
        logic prg;
    } strobes_t;

    localparam logic [7:0] SYNC_FIRST  = 8'hFF;
    localparam logic [7:0] SYNC_SECOND = 8'h20;
    localparam int         ST_INIT     = 1;
    localparam int         ST_TXRDY    = 2;
    localparam logic [3:0] VER_HANDSHK = 4'h5;

    // strobe levels per step of the attempt sequence
    function automatic strobes_t strobe_at(input logic [2:0] step);
        strobes_t s;
        s = '0;
        case (step)
            3'd0: s.lbr = 1'b1;
            3'd3: s.rld = 1'b1;
            3'd5: s.prg = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ldr_pulse_seq.sv
module ldr_pulse_seq #(
    parameter int PULSE_W = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic short_i,
    output logic lbr,
    output logic rld,
    output logic prg,
    output logic fin
);
    localparam int PW_W = $clog2(PULSE_W + 1);

    logic            active;
    logic            short_q;
    logic [2:0]      step;
    logic [PW_W-1:0] tmr;
    ldr_pkg::strobes_t lv;

    always_comb begin
        lv  = active ? ldr_pkg::strobe_at(step) : '0;
        lbr = lv.lbr;
        rld = lv.rld;
        prg = lv.prg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            short_q <= 1'b0;
            step    <= '0;
            tmr     <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active  <= 1'b1;
                short_q <= short_i;
                step    <= '0;
                tmr     <= PW_W'(PULSE_W - 1);
            end else if (active) begin
                if (tmr == '0) begin
                    if (step == (short_q ? 3'd4 : 3'd6)) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        step <= step + 3'd1;
                        tmr  <= PW_W'(PULSE_W - 1);
                    end
                end else begin
                    tmr <= tmr - PW_W'(1);
                end
            end
        end
    end

    // R4: a started sequence is running on the next cycle
    a_r4_seq_starts: assert property (@(posedge clk) disable iff (rst)
        go |=> active);
    // R4: completion is reported only by a running sequence
    a_r4_fin_from_active: assert property (@(posedge clk) disable iff (rst)
        fin |-> $past(active));

endmodule

// File: rtl/ldr_poller.sv
module ldr_poller #(
    parameter int GAP   = 500,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             cond,
    input  logic [CNT_W-1:0] limit,
    output logic             hit,
    output logic             miss
);
    localparam int GAP_W = $clog2(GAP + 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [GAP_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            tmr    <= '0;
            hit    <= 1'b0;
            miss   <= 1'b0;
        end else begin
            hit  <= 1'b0;
            miss <= 1'b0;
            if (go) begin
                active <= 1'b1;
                cnt    <= '0;
                tmr    <= '0;
            end else if (active) begin
                if (tmr == '0) begin
                    if (cond) begin
                        hit    <= 1'b1;
                        active <= 1'b0;
                    end else if (cnt == limit - CNT_W'(1)) begin
                        miss   <= 1'b1;
                        active <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                        tmr <= GAP_W'(GAP - 1);
                    end
                end else begin
                    tmr <= tmr - GAP_W'(1);
                end
            end
        end
    end

    // R5: give-up is only reported by a running poll
    a_r5_miss_from_active: assert property (@(posedge clk) disable iff (rst)
        miss |-> $past(active));
    // R5: a poll ends in exactly one outcome
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        hit |-> !miss);

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
    parameter int LEN_W        = 12,
    parameter int PULSE_W      = 1000,
    parameter int POLL_GAP     = 500,
    parameter int FIXED_POLLS  = 4,
    parameter int INIT_TRIES   = 50,
    parameter int TX_TRIES     = 100,
    parameter int DONE_TRIES   = 200,
    parameter int MAX_ATTEMPTS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] img_len_i,
    output logic [LEN_W-1:0] rom_addr_o,
    input  logic [7:0]       rom_data_i,
    input  logic             mem_present_i,
    input  logic [15:0]      stat_i,
    input  logic             cfg_done_i,
    output logic [15:0]      cfg_wdata_o,
    output logic             cfg_we_o,
    output logic             lbus_rst_o,
    output logic             reload_o,
    output logic             prog_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       err_o
);
    import ldr_pkg::*;

    localparam int CNT_W = $clog2(INIT_TRIES + TX_TRIES + DONE_TRIES + FIXED_POLLS + 1);
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    ldr_state_e       state;
    poll_sel_e        poll_sel;
    ldr_err_e         err_q, fail_code;
    logic [LEN_W-1:0] ptr, start_q, remain;
    logic [7:0]       prev, hi_q, lo_q;
    logic             have_prev, new_ver, final_ph, done_q, att_fail;
    logic [ATT_W-1:0] attempt;
    logic             pulse_go, pulse_short, pulse_fin;
    logic             poll_go, poll_cond, poll_hit, poll_miss;
    logic [CNT_W-1:0] poll_limit;

    ldr_pulse_seq #(.PULSE_W(PULSE_W)) u_seq (
        .clk(clk), .rst(rst), .go(pulse_go), .short_i(pulse_short),
        .lbr(lbus_rst_o), .rld(reload_o), .prg(prog_o), .fin(pulse_fin)
    );

    ldr_poller #(.GAP(POLL_GAP), .CNT_W(CNT_W)) u_poll (
        .clk(clk), .rst(rst), .go(poll_go), .cond(poll_cond),
        .limit(poll_limit), .hit(poll_hit), .miss(poll_miss)
    );

    always_comb begin
        case (poll_sel)
            P_INIT:  begin poll_cond = stat_i[ST_INIT];  poll_limit = CNT_W'(INIT_TRIES);  end
            P_TX:    begin poll_cond = stat_i[ST_TXRDY]; poll_limit = CNT_W'(TX_TRIES);    end
            P_DONE:  begin poll_cond = cfg_done_i;       poll_limit = CNT_W'(DONE_TRIES);  end
            default: begin poll_cond = 1'b0;             poll_limit = CNT_W'(FIXED_POLLS); end
        endcase
    end

    always_comb begin
        att_fail  = 1'b0;
        fail_code = ERR_NONE;
        if ((state == S_INIT || state == S_DONEW || (state == S_PACE && new_ver)) && poll_miss) begin
            att_fail  = 1'b1;
            fail_code = ERR_TIMEOUT;
        end else if (state == S_VERIFY && !stat_i[ST_INIT]) begin
            att_fail  = 1'b1;
            fail_code = ERR_IO;
        end
    end

    assign remain      = img_len_i - ptr + ONE;
    assign rom_addr_o  = (state == S_FETCH_L) ? ptr + ONE : ptr;
    assign cfg_wdata_o = {hi_q, lo_q};
    assign cfg_we_o    = (state == S_WRITE);
    assign busy_o      = (state != S_IDLE);
    assign done_o      = done_q;
    assign err_o       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            poll_sel    <= P_INIT;
            err_q       <= ERR_NONE;
            done_q      <= 1'b0;
            ptr         <= '0;
            start_q     <= '0;
            prev        <= '0;
            hi_q        <= '0;
            lo_q        <= '0;
            have_prev   <= 1'b0;
            new_ver     <= 1'b0;
            final_ph    <= 1'b0;
            attempt     <= '0;
            pulse_go    <= 1'b0;
            pulse_short <= 1'b0;
            poll_go     <= 1'b0;
        end else begin
            pulse_go <= 1'b0;
            poll_go  <= 1'b0;
            if (att_fail) begin
                if (attempt == ATT_W'(MAX_ATTEMPTS - 1)) begin
                    err_q <= fail_code;
                    state <= S_IDLE;
                end else begin
                    attempt     <= attempt + ATT_W'(1);
                    pulse_go    <= 1'b1;
                    pulse_short <= 1'b0;
                    state       <= S_PULSE;
                end
            end else begin
                case (state)
                    S_IDLE: if (start_i) begin
                        done_q    <= 1'b0;
                        err_q     <= ERR_NONE;
                        ptr       <= '0;
                        have_prev <= 1'b0;
                        if (img_len_i < TWO) err_q <= ERR_IMAGE;
                        else                 state <= S_SCAN;
                    end
                    S_SCAN: begin
                        if (have_prev && prev == SYNC_FIRST && rom_data_i == SYNC_SECOND) begin
                            start_q <= ptr - ONE;
                            if (remain[0]) begin
                                err_q <= ERR_IMAGE;
                                state <= S_IDLE;
                            end else if (!mem_present_i) begin
                                err_q <= ERR_IO;
                                state <= S_IDLE;
                            end else begin
                                attempt     <= '0;
                                final_ph    <= 1'b0;
                                pulse_go    <= 1'b1;
                                pulse_short <= 1'b0;
                                state       <= S_PULSE;
                            end
                        end else if (ptr == img_len_i - ONE) begin
                            err_q <= ERR_IMAGE;
                            state <= S_IDLE;
                        end else begin
                            prev      <= rom_data_i;
                            have_prev <= 1'b1;
                            ptr       <= ptr + ONE;
                        end
                    end
                    S_PULSE: if (pulse_fin) begin
                        if (final_ph) begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end else begin
                            poll_sel <= P_INIT;
                            poll_go  <= 1'b1;
                            state    <= S_INIT;
                        end
                    end
                    S_INIT: if (poll_hit) begin
                        new_ver <= (stat_i[15:12] == VER_HANDSHK);
                        ptr     <= start_q;
                        state   <= S_FETCH_H;
                    end
                    S_FETCH_H: begin
                        hi_q  <= rom_data_i;
                        state <= S_FETCH_L;
                    end
                    S_FETCH_L: begin
                        lo_q     <= rom_data_i;
                        poll_sel <= new_ver ? P_TX : P_WAIT;
                        poll_go  <= 1'b1;
                        state    <= S_PACE;
                    end
                    S_PACE: if (new_ver ? poll_hit : poll_miss) state <= S_WRITE;
                    S_WRITE: state <= S_VERIFY;
                    S_VERIFY: begin
                        if ({1'b0, ptr} + {1'b0, TWO} == {1'b0, img_len_i}) begin
                            poll_sel <= P_DONE;
                            poll_go  <= 1'b1;
                            state    <= S_DONEW;
                        end else begin
                            ptr   <= ptr + TWO;
                            state <= S_FETCH_H;
                        end
                    end
                    S_DONEW: if (poll_hit) begin
                        final_ph    <= 1'b1;
                        pulse_go    <= 1'b1;
                        pulse_short <= 1'b1;
                        state       <= S_PULSE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R12: an accepted start raises busy
    a_r12_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && img_len_i >= TWO) |=> busy_o);
    // R12: results are held while idle without a start
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(err_o) && $stable(done_o)));
    // R9: success carries no error code
    a_r9_done_clean: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o == ERR_NONE));
    // R8: each write is a single cycle followed by the status check
    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we_o |=> !cfg_we_o);
    // R11: no strobe activity outside a load
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!prog_o && !lbus_rst_o && !reload_o));

endmodule

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;

    localparam int PW = 2;
    localparam int GAPC = 3;
    localparam int FIXP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  img_len_i = 8'd0;
    logic [7:0]  rom_addr_o;
    logic [7:0]  rom_data_i;
    logic        mem_present_i = 1'b1;
    logic [15:0] stat_i;
    logic        cfg_done_i;
    logic [15:0] cfg_wdata_o;
    logic        cfg_we_o, lbus_rst_o, reload_o, prog_o, busy_o, done_o;
    logic [1:0]  err_o;

    always #10 clk = ~clk;

    cfg_image_loader #(
        .LEN_W(8), .PULSE_W(PW), .POLL_GAP(GAPC), .FIXED_POLLS(FIXP),
        .INIT_TRIES(50), .TX_TRIES(100), .DONE_TRIES(200), .MAX_ATTEMPTS(3)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .img_len_i(img_len_i),
        .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .mem_present_i(mem_present_i), .stat_i(stat_i), .cfg_done_i(cfg_done_i),
        .cfg_wdata_o(cfg_wdata_o), .cfg_we_o(cfg_we_o), .lbus_rst_o(lbus_rst_o),
        .reload_o(reload_o), .prog_o(prog_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // image contents: sel 0 marker at 3, sel 1 no marker, sel 2 marker at 1
    function automatic logic [7:0] img_byte(input logic [1:0] sel, input logic [7:0] a);
        logic [7:0] f;
        f = (a * 8'd7 + 8'd1) & 8'h7F;
        case (sel)
            2'd0: return (a == 8'd3) ? 8'hFF : (a == 8'd4) ? 8'h20 : f;
            2'd2: return (a <= 8'd1) ? 8'hFF : (a == 8'd2) ? 8'h20 : f;
            default: return f;
        endcase
    endfunction

    // target model configuration
    logic [1:0] m_sel = 2'd0;
    logic [3:0] m_ver = 4'h5;
    logic [1:0] m_ifail = 2'd0;
    logic       m_tx_ok = 1'b1;
    logic [7:0] m_io_at = 8'hFF;
    logic       m_done_ok = 1'b1;
    logic [7:0] m_expw = 8'd0;
    logic       mclr = 1'b0;

    // target model state
    logic       init_r, lbr_q, rld_q, prg_q;
    logic [2:0] txwait;
    logic [1:0] phase;
    int         prog_rises, lbr_rises, wcnt, wtotal, order_viol, width_viol, tx_viol;
    int         hl, hr, hp, since_last, min_gap;
    logic [15:0] words [0:63];
    logic       txready;

    assign txready    = m_tx_ok && (txwait == 3'd0);
    assign stat_i     = {m_ver, 9'd0, txready, init_r, 1'b0};
    assign cfg_done_i = m_done_ok && init_r && (wcnt == int'(m_expw)) && (wcnt != 0);
    assign rom_data_i = img_byte(m_sel, rom_addr_o);

    always @(posedge clk) begin
        if (mclr) begin
            init_r <= 1'b0; lbr_q <= 1'b0; rld_q <= 1'b0; prg_q <= 1'b0;
            txwait <= 3'd0; phase <= 2'd0;
            prog_rises <= 0; lbr_rises <= 0; wcnt <= 0; wtotal <= 0;
            order_viol <= 0; width_viol <= 0; tx_viol <= 0;
            hl <= 0; hr <= 0; hp <= 0; since_last <= 0; min_gap <= 255;
        end else begin
            lbr_q <= lbus_rst_o; rld_q <= reload_o; prg_q <= prog_o;
            hl <= lbus_rst_o ? hl + 1 : 0;
            hr <= reload_o ? hr + 1 : 0;
            hp <= prog_o ? hp + 1 : 0;
            if (!lbus_rst_o && lbr_q && hl != PW) width_viol <= width_viol + 1;
            if (!reload_o && rld_q && hr != PW) width_viol <= width_viol + 1;
            if (!prog_o && prg_q && hp != PW) width_viol <= width_viol + 1;
            if (lbus_rst_o && !lbr_q) begin
                init_r <= 1'b0;
                lbr_rises <= lbr_rises + 1;
                if (phase != 2'd0) order_viol <= order_viol + 1;
                phase <= 2'd1;
            end
            if (reload_o && !rld_q) begin
                if (phase != 2'd1) order_viol <= order_viol + 1;
                phase <= 2'd2;
            end
            if (prog_o && !prg_q) begin
                if (phase != 2'd2) order_viol <= order_viol + 1;
                phase <= 2'd0;
                prog_rises <= prog_rises + 1;
                wcnt <= 0;
            end
            if (!prog_o && prg_q) init_r <= (prog_rises > int'(m_ifail));
            if (cfg_we_o) begin
                if (wcnt < 64) words[wcnt] <= cfg_wdata_o;
                wcnt <= wcnt + 1;
                wtotal <= wtotal + 1;
                txwait <= 3'd3;
                if (wcnt == int'(m_io_at)) init_r <= 1'b0;
                if (m_ver == 4'h5 && !txready) tx_viol <= tx_viol + 1;
                if (wcnt > 0 && since_last < min_gap) min_gap <= since_last;
                since_last <= 1;
            end else begin
                since_last <= since_last + 1;
                if (txwait != 3'd0) txwait <= txwait - 3'd1;
            end
        end
    end

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] len;
        logic [3:0] ver;
        logic [1:0] ifail;
        logic       tx_ok;
        logic [7:0] io_at;
        logic       done_ok;
        logic       mem;
        logic [1:0] eerr;
        logic [1:0] eatt;
    } case_t;

    localparam int NCASE = 15;
    localparam case_t CASES [NCASE] = '{
        '{2'd0, 8'd19, 4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd1}, // R3 R6 handshake ok
        '{2'd0, 8'd19, 4'h3, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd1}, // R7 fixed wait ok
        '{2'd1, 8'd20, 4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd1, 2'd0}, // R1 no marker
        '{2'd0, 8'd18, 4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd1, 2'd0}, // R2 odd remainder
        '{2'd0, 8'd1,  4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd1, 2'd0}, // R1 too short
        '{2'd0, 8'd19, 4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b0, 2'd3, 2'd0}, // R11 memory absent
        '{2'd0, 8'd19, 4'h5, 2'd3, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd2, 2'd3}, // R5 never ready
        '{2'd0, 8'd19, 4'h5, 2'd2, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd3}, // R10 third attempt ok
        '{2'd0, 8'd19, 4'h3, 2'd1, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd2}, // R10 second attempt ok
        '{2'd0, 8'd19, 4'h5, 2'd0, 1'b0, 8'hFF, 1'b1, 1'b1, 2'd2, 2'd3}, // R6 tx never ready
        '{2'd0, 8'd19, 4'h5, 2'd0, 1'b1, 8'd2,  1'b1, 1'b1, 2'd3, 2'd3}, // R8 ready lost
        '{2'd0, 8'd19, 4'h5, 2'd0, 1'b1, 8'hFF, 1'b0, 1'b1, 2'd2, 2'd3}, // R9 done never
        '{2'd2, 8'd13, 4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd1}, // R1 first pair wins
        '{2'd0, 8'd19, 4'h3, 2'd0, 1'b0, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd1}, // R7 tx bit ignored
        '{2'd0, 8'd5,  4'h5, 2'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd1}  // R3 marker at end
    };

    task automatic run_case(input case_t c, input bit poke);
        int cyc;
        int st, nw;
        st = (c.sel == 2'd2) ? 1 : 3;
        nw = (int'(c.len) - st) / 2;
        @(negedge clk);
        m_sel = c.sel; m_ver = c.ver; m_ifail = c.ifail; m_tx_ok = c.tx_ok;
        m_io_at = c.io_at; m_done_ok = c.done_ok; m_expw = 8'(nw);
        mem_present_i = c.mem; img_len_i = c.len;
        mclr = 1'b1;
        @(negedge clk);
        mclr = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (busy_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 40) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(err_o == c.eerr, "R10 error code", int'(err_o), int'(c.eerr));
        chk(done_o == (c.eerr == 2'd0), "R9 done flag", int'(done_o), int'(c.eerr == 2'd0));
        chk(prog_rises == int'(c.eatt), "R10 attempt count", prog_rises, int'(c.eatt));
        chk(order_viol == 0, "R4 strobe order", order_viol, 0);
        chk(width_viol == 0, "R4 strobe width", width_viol, 0);
        if (c.eatt == 2'd0)
            chk(wtotal == 0 && lbr_rises == 0, "R11 no activity on early failure", wtotal, 0);
        if (c.eerr == 2'd0) begin
            chk(wcnt == nw, "R3 word count", wcnt, nw);
            for (int k = 0; k < nw; k++) begin
                logic [15:0] ew;
                ew = {img_byte(c.sel, 8'(st + 2 * k)), img_byte(c.sel, 8'(st + 2 * k + 1))};
                chk(words[k] == ew, "R3 word value", int'(words[k]), int'(ew));
            end
            chk(lbr_rises == prog_rises + 1, "R9 closing reset pulse", lbr_rises, prog_rises + 1);
            if (c.ver != 4'h5 && nw > 1)
                chk(min_gap >= (FIXP - 1) * GAPC, "R7 fixed wait", min_gap, (FIXP - 1) * GAPC);
        end
        if (c.ver == 4'h5)
            chk(tx_viol == 0, "R6 write without tx ready", tx_viol, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        mclr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mclr = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy_o && !done_o && err_o == 2'd0, "R12 reset outputs", int'({busy_o, done_o, err_o}), 0);
        chk(!lbus_rst_o && !reload_o && !prog_o && !cfg_we_o, "R4 reset strobes",
            int'({lbus_rst_o, reload_o, prog_o, cfg_we_o}), 0);

        for (int i = 0; i < NCASE; i++) run_case(CASES[i], 1'b0);

        // R12: start during busy is ignored; result still that of one clean attempt
        run_case(CASES[0], 1'b1);
        // R12: results hold while idle
        begin
            logic [1:0] e0;
            logic d0;
            run_case(CASES[9], 1'b0);
            e0 = err_o; d0 = done_o;
            repeat (30) @(negedge clk);
            chk(err_o == e0 && done_o == d0, "R12 error held", int'(err_o), int'(e0));
            chk(!busy_o, "R12 stays idle", int'(busy_o), 0);
            // R12: a new start clears the prior error
            run_case(CASES[1], 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule